// File: doc/BRIEF.md
# Vector multiply-shift accelerator

This block computes, for a run of signed 16-bit element pairs, the product of each pair scaled down by a run-time right shift. Software programs three byte base addresses, a shift amount and an element count through a small register port, then sets a start bit. The block then walks the two input arrays and the output array in step, one element per iteration, and raises a done flag when the last result has been written.

Both input arrays sit in one memory behind a single read master, so the two reads of an element are issued one after the other. Results leave through a separate write master into a different memory. The arrays are assumed not to overlap, so no ordering checks are made between reads and writes. Each result is the 32-bit signed product shifted right arithmetically and cut back to its low 16 bits.

Top module: `vmulshift_accel`

## Requirements
- R1: After reset the block is idle: the status reads busy = 0 and done = 0, and neither master issues a request.
- R2: Register offsets on csr_addr: 0 = control/status (writing bit 0 = 1 starts a run; reading gives bit 0 busy, bit 1 done), 1 = first input base, 2 = second input base, 3 = output base, 4 = shift amount (only bits 4:0 kept), 5 = signed 32-bit element count. Offsets 1 to 5 read back what was written.
- R3: Each output element equals bits 15:0 of (signed first input × signed second input), a 32-bit product, shifted right arithmetically by the shift amount (0 to 31).
- R4: For element i the block reads the first input at base1 + 2i, then the second input at base2 + 2i, then writes the result at base3 + 2i; the two masters never request in the same cycle, and a new read is issued only after the previous read data has arrived.
- R5: A request stays asserted, with address (and write data) unchanged, for as long as its wait input is high; a transfer happens in a cycle with request high and wait low.
- R6: Read data is taken in the cycle rd_dvalid is high; any number of cycles (at least one) may pass between acceptance and data valid without changing results.
- R7: A start with a count of zero or less sets done in the next cycle, leaves busy low, and makes no memory access.
- R8: A start while busy is ignored, and register writes during a run do not change that run: it completes with the count, shift and bases in force at its start.
- R9: Done is set in the cycle after the final write is accepted, together with busy falling; a start that begins a run clears done.
- R10: A run with count N > 0 performs exactly 2N read transfers and N write transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | CAW (3) | Register offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW (32) | Read byte address |
| rd_wait | input | 1 | Read request stall |
| rd_dvalid | input | 1 | Read data valid |
| rd_data | input | DW (16) | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW (32) | Write byte address |
| wr_data | output | DW (16) | Write data |
| wr_wait | input | 1 | Write request stall |

## Verification
The hardest situation to reach is the final write of a run held off by the write wait while the block must keep done low, together with a start arriving in the middle of a run after the count has been rewritten. The bench forces the write wait high once the first result has landed, checks status during the stall, and releases it to time the rise of done; a second test rewrites the count and pulses start a few cycles into a run, then counts writes. Random read and write stalls with a three-cycle read latency exercise the hold rules over a longer run.

// File: rtl/vmulshift_accel.sv
module vmulshift_accel #(
  parameter int AW  = 32,
  parameter int DW  = 16,
  parameter int LW  = 32,
  parameter int CAW = 3,
  localparam int PW   = 2 * DW,
  localparam int SW   = $clog2(PW),
  localparam int STEP = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           csr_wr,
  input  logic [CAW-1:0] csr_addr,
  input  logic [31:0]    csr_wdata,
  output logic [31:0]    csr_rdata,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_wait,
  input  logic           rd_dvalid,
  input  logic [DW-1:0]  rd_data,
  output logic           wr_req,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  input  logic           wr_wait
);

  typedef enum logic [2:0] {S_IDLE, S_RDV, S_WTV, S_RDC, S_WTC, S_WR} st_t;

  st_t            st;
  logic [AW-1:0]  cfg_a, cfg_b, cfg_o;
  logic [SW-1:0]  cfg_sh;
  logic [LW-1:0]  cfg_len;
  logic [AW-1:0]  aptr, bptr, optr;
  logic [SW-1:0]  sh_q;
  logic [LW-1:0]  left;
  logic [DW-1:0]  a_q, b_q;
  logic           done_q;
  logic           busy;
  logic           start;
  logic signed [PW-1:0] prod, shd;

  assign busy  = (st != S_IDLE);
  assign start = csr_wr && (csr_addr == CAW'(0)) && csr_wdata[0];

  assign prod = $signed(a_q) * $signed(b_q);
  assign shd  = prod >>> sh_q;

  assign rd_req  = (st == S_RDV) || (st == S_RDC);
  assign rd_addr = (st == S_RDC) ? bptr : aptr;
  assign wr_req  = (st == S_WR);
  assign wr_addr = optr;
  assign wr_data = shd[DW-1:0];

  always_comb begin
    case (csr_addr)
      CAW'(0): csr_rdata = {30'd0, done_q, busy};
      CAW'(1): csr_rdata = 32'(cfg_a);
      CAW'(2): csr_rdata = 32'(cfg_b);
      CAW'(3): csr_rdata = 32'(cfg_o);
      CAW'(4): csr_rdata = 32'(cfg_sh);
      CAW'(5): csr_rdata = 32'(cfg_len);
      default: csr_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cfg_a   <= '0;
      cfg_b   <= '0;
      cfg_o   <= '0;
      cfg_sh  <= '0;
      cfg_len <= '0;
      aptr    <= '0;
      bptr    <= '0;
      optr    <= '0;
      sh_q    <= '0;
      left    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      if (csr_wr) begin
        case (csr_addr)
          CAW'(1): cfg_a   <= csr_wdata[AW-1:0];
          CAW'(2): cfg_b   <= csr_wdata[AW-1:0];
          CAW'(3): cfg_o   <= csr_wdata[AW-1:0];
          CAW'(4): cfg_sh  <= csr_wdata[SW-1:0];
          CAW'(5): cfg_len <= csr_wdata[LW-1:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (start) begin
          if ($signed(cfg_len) <= 0) begin
            done_q <= 1'b1;
          end else begin
            done_q <= 1'b0;
            aptr   <= cfg_a;
            bptr   <= cfg_b;
            optr   <= cfg_o;
            sh_q   <= cfg_sh;
            left   <= cfg_len;
            st     <= S_RDV;
          end
        end
        S_RDV: if (!rd_wait) st <= S_WTV;
        S_WTV: if (rd_dvalid) begin
          a_q <= rd_data;
          st  <= S_RDC;
        end
        S_RDC: if (!rd_wait) st <= S_WTC;
        S_WTC: if (rd_dvalid) begin
          b_q <= rd_data;
          st  <= S_WR;
        end
        S_WR: if (!wr_wait) begin
          aptr <= aptr + AW'(STEP);
          bptr <= bptr + AW'(STEP);
          optr <= optr + AW'(STEP);
          left <= left - LW'(1);
          if (left == LW'(1)) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_RDV;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module vmul_chk #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int LW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_req,
  input logic                 rd_wait,
  input logic [AW-1:0]        rd_addr,
  input logic                 wr_req,
  input logic                 wr_wait,
  input logic [AW-1:0]        wr_addr,
  input logic [DW-1:0]        wr_data,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic signed [LW-1:0] len
);

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_wait) |=> (rd_req && $stable(rd_addr)));

  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_wait) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_one_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  assert_empty_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len <= 0) |=> (done && !busy && !rd_req && !wr_req));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !rd_req && !wr_req));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len > 0) |=> (busy && !done));

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !wr_req) |=> busy);

endmodule

bind vmulshift_accel vmul_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_req(rd_req), .rd_wait(rd_wait), .rd_addr(rd_addr),
  .wr_req(wr_req), .wr_wait(wr_wait), .wr_addr(wr_addr), .wr_data(wr_data),
  .start(start), .busy(busy), .done(done_q), .len(cfg_len)
);

// File: tb/sim_vmulshift_accel.sv
`timescale 1ns/1ps
module sim_vmulshift_accel;
  localparam int AB = 32'h100, BB = 32'h400, OB = 32'h200;

  logic clk = 0, rst_n = 0;
  logic csr_wr = 0;
  logic [2:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic rd_req, rd_wait = 0, rd_dvalid = 0;
  logic [31:0] rd_addr, wr_addr;
  logic [15:0] rd_data = 0, wr_data;
  logic wr_req, wr_wait = 0;

  vmulshift_accel u0 (.*);

  always #2 clk = ~clk;

  int ncmp = 0, nfail = 0, cyc = 0;
  logic [15:0] rmem [0:1023];
  logic [15:0] wmem [0:1023];
  logic [31:0] rlog [0:255];
  logic [31:0] wlog [0:255];
  int nrd = 0, nwr = 0;
  bit rstall = 0, wstall = 0, wforce = 0;
  int lat = 1;
  logic [15:0] lfsr = 16'hACE1;
  bit rpend = 0;
  int rcnt = 0;
  logic [31:0] raddr = 0;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      ncmp++; nfail++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      finish_run();
    end
  end

  always @(negedge clk) begin
    bit wch, rch;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_dvalid = 0;
    if (rpend) begin
      if (rcnt <= 1) begin
        rd_dvalid = 1; rd_data = rmem[raddr[10:1]]; rpend = 0;
      end else rcnt--;
    end else begin
      rch = rstall && lfsr[0];
      rd_wait = rch;
      if (rd_req && !rch) begin
        rpend = 1; rcnt = lat; raddr = rd_addr;
        if (nrd < 256) rlog[nrd] = rd_addr;
        nrd++;
      end
    end
    wch = wforce || (wstall && lfsr[3]);
    wr_wait = wch;
    if (wr_req && !wch) begin
      wmem[wr_addr[10:1]] = wr_data;
      if (nwr < 256) wlog[nwr] = wr_addr;
      nwr++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_out(logic [15:0] a, logic [15:0] b, int sh);
    logic signed [31:0] p;
    p = $signed(a) * $signed(b);
    p = p >>> sh;
    return p[15:0];
  endfunction

  task automatic csr_w(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 0;
  endtask

  task automatic csr_r(input logic [2:0] a, output logic [31:0] d);
    csr_addr = a;
    #0.1;
    d = csr_rdata;
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      rmem[(AB >> 1) + i] = 16'((i + 1) * 16'h1357 + seed * 4099);
      rmem[(BB >> 1) + i] = 16'((i + 3) * 16'h2B1D - seed * 611);
      wmem[(OB >> 1) + i] = 16'hDEAD;
    end
  endtask

  task automatic launch(input int len, input int sh);
    csr_w(1, AB); csr_w(2, BB); csr_w(3, OB);
    csr_w(4, sh); csr_w(5, len);
    nrd = 0; nwr = 0;
    csr_w(0, 1);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      csr_r(0, s);
      if (s[1]) break;
    end
  endtask

  task automatic verify(input int n, input int sh, input string req);
    for (int i = 0; i < n; i++)
      chk(req, wmem[(OB >> 1) + i],
          ref_out(rmem[(AB >> 1) + i], rmem[(BB >> 1) + i], sh));
  endtask

  task automatic verify_order(input int n);
    for (int i = 0; i < n; i++) begin
      chk("R4 first read addr", rlog[2*i], AB + 2*i);
      chk("R4 second read addr", rlog[2*i+1], BB + 2*i);
      chk("R4 write addr", wlog[i], OB + 2*i);
    end
    chk("R10 read count", nrd, 2*n);
    chk("R10 write count", nwr, n);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    @(negedge clk);
    csr_r(0, s);
    chk("R1 status", s, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 wr_req", wr_req, 0);
  endtask

  task automatic t_csr();
    logic [31:0] d;
    csr_w(1, 32'h1234_5678); csr_w(2, 32'h0BAD_F00E);
    csr_w(3, 32'h0000_0A0A); csr_w(4, 32'h3F); csr_w(5, 32'hFFFF_FFF0);
    csr_r(1, d); chk("R2 base1", d, 32'h1234_5678);
    csr_r(2, d); chk("R2 base2", d, 32'h0BAD_F00E);
    csr_r(3, d); chk("R2 base3", d, 32'h0000_0A0A);
    csr_r(4, d); chk("R2 shift 5 bits", d, 32'h1F);
    csr_r(5, d); chk("R2 count", d, 32'hFFFF_FFF0);
  endtask

  task automatic t_basic();
    logic [31:0] s;
    fill(6, 1);
    launch(6, 0);
    wait_done();
    csr_r(0, s); chk("R9 status after run", s, 2);
    verify(6, 0, "R3 shift 0");
    verify_order(6);
  endtask

  task automatic t_shift();
    int shs [4] = '{1, 8, 15, 31};
    foreach (shs[j]) begin
      fill(4, j + 7);
      rmem[AB >> 1] = 16'h7FFF; rmem[BB >> 1] = 16'h7FFF;
      rmem[(AB >> 1) + 1] = 16'h8000; rmem[(BB >> 1) + 1] = 16'h0003;
      launch(4, shs[j]);
      wait_done();
      verify(4, shs[j], "R3 shift/sign");
    end
    fill(1, 2);
    rmem[AB >> 1] = 16'h7FFF; rmem[BB >> 1] = 16'h7FFF;
    launch(1, 0);
    wait_done();
    chk("R3 truncation", wmem[OB >> 1], 16'h0001);
  endtask

  task automatic t_stall();
    rstall = 1; wstall = 1; lat = 3;
    fill(16, 5);
    launch(16, 4);
    wait_done();
    verify(16, 4, "R5 R6 stalled run");
    verify_order(16);
    rstall = 0; wstall = 0; lat = 1;
  endtask

  task automatic t_empty();
    logic [31:0] s;
    launch(0, 0);
    @(negedge clk);
    csr_r(0, s); chk("R7 zero count status", s, 2);
    launch(-3, 0);
    @(negedge clk);
    csr_r(0, s); chk("R7 negative count status", s, 2);
    repeat (10) @(negedge clk);
    chk("R7 no reads", nrd, 0);
    chk("R7 no writes", nwr, 0);
  endtask

  task automatic t_busy();
    logic [31:0] s;
    fill(8, 9);
    launch(8, 2);
    repeat (3) @(negedge clk);
    csr_w(5, 2); csr_w(4, 9); csr_w(3, 32'h300);
    csr_w(0, 1);
    wait_done();
    verify(8, 2, "R8 run unchanged");
    repeat (20) @(negedge clk);
    csr_r(0, s); chk("R8 idle after run", s, 2);
    chk("R8 write count", nwr, 8);
    csr_w(5, 8); csr_w(4, 2); csr_w(3, OB);
  endtask

  task automatic t_done();
    logic [31:0] s;
    int k;
    fill(2, 3);
    launch(2, 1);
    @(negedge clk);
    csr_r(0, s); chk("R9 start clears done", s, 1);
    while (nwr < 1) @(negedge clk);
    wforce = 1;
    while (!wr_req) @(negedge clk);
    repeat (6) @(negedge clk);
    csr_r(0, s); chk("R9 done held during final write stall", s, 1);
    chk("R9 one write so far", nwr, 1);
    wforce = 0;
    k = 0;
    do begin
      @(negedge clk); k++;
      csr_r(0, s);
    end while (!s[1] && k < 10);
    chk("R9 done cycles after release", k, 2);
    chk("R9 final write count", nwr, 2);
    verify(2, 1, "R9 results");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin rmem[i] = 0; wmem[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_csr();
    t_basic();
    t_shift();
    t_stall();
    t_empty();
    t_busy();
    t_done();
    finish_run();
  end
endmodule